// File: doc/BRIEF.md
# Structured Vector Load/Store Sequencer

This block carries out one multi-register structured vector transfer between memory and a 32-entry file of 64-bit vector registers. A caller presents a 32-bit instruction word and a base address together with a one-cycle start strobe. The sequencer decodes the transfer shape from the word. It then walks memory one element at a time through a single request port. Loaded elements are gathered into register images. For stores, register images are split into elements.

The transfer shape comes from a fixed table of eleven formats. Each format gives how many registers take part, how many registers share one interleaved structure, and how far the register index moves between registers. Address restart rules spread the elements of each structure across the registers. The base address is supplied by the caller; the instruction's base-register field is not decoded here. An unknown format produces an error pulse and no memory traffic.

The controller is a single state machine. Its states are IDLE (wait for start), SETUP (apply the address restart rule for the current register and, for a store, read that register), FETCH (capture store data), ACCESS (hold one memory request until it is accepted), WRITE (write an assembled register on a load) and FINISH (done pulse). Transitions: IDLE to SETUP on a legal start; SETUP to ACCESS on a load or to FETCH on a store; FETCH to ACCESS; ACCESS back to itself until the last element of the register is accepted, then to WRITE on a load, or to SETUP or FINISH on a store; WRITE to SETUP or FINISH; FINISH to IDLE.

Top module: `vstruct_seq`

## Requirements
- R1: Instruction fields: format code in bits [11:8], element size code in bits [7:6], direction in bit 21 (1 = load, 0 = store), first register index with bits [3:0] from bits [15:12] and bit 4 from bit 22.
- R2: Format codes 0 to 10 map to (registers, interleave, spacing): 0:(4,4,1) 1:(4,4,2) 2:(4,1,1) 3:(4,2,1) 4:(3,3,1) 5:(3,3,2) 6:(3,1,1) 7:(1,1,1) 8:(2,2,1) 9:(2,2,2) 10:(2,1,1); each register takes 8 >> size elements.
- R3: An element is 2^size bytes, mem_size_o carries the size code on every request, and the address advances by element bytes times interleave after each accepted element.
- R4: At the start of register r the address restarts at base + esize·r when interleave exceeds 2 or when interleave is 2 with two registers; with interleave 2 and four registers register 2 restarts at base + esize; otherwise the running address continues (register 0 starts at base).
- R5: Element i of a register sits at bit i·esize·8 of the 64-bit image (little-endian); element data travels in the low esize·8 bits of mem_wdata_o and mem_rdata_i.
- R6: After each register the register index advances by the format's spacing, wrapping modulo 32.
- R7: At most one memory request is outstanding; a request not yet accepted keeps its address, direction and size until mem_ready_i.
- R8: A load writes each register exactly once, in the cycle after its last element is accepted, and never writes on a store.
- R9: A store reads each register once, one cycle before its capture, before the first memory request of that register.
- R10: done_o is a one-cycle pulse, high in the cycle after the final store acceptance or after the final load register write.
- R11: Format codes 11 to 15 raise err_o for one cycle in the cycle after start, with no memory request and no done pulse.
- R12: A start strobe while a transfer is in progress is ignored.
- R13: After reset there is no memory request, no register file access, no done and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| instr_i | input | 32 | Transfer instruction word |
| base_i | input | AW | Base address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the element |
| mem_size_o | output | 2 | Element size code |
| mem_wdata_o | output | DW | Store element, low-aligned |
| mem_rdata_i | input | DW | Load element, low-aligned, valid with ready |
| mem_ready_i | input | 1 | Request accepted this cycle |
| vrf_re_o | output | 1 | Register file read enable |
| vrf_raddr_o | output | 5 | Register file read index |
| vrf_rdata_i | input | DW | Read data, one cycle after enable |
| vrf_we_o | output | 1 | Register file write enable |
| vrf_waddr_o | output | 5 | Register file write index |
| vrf_wdata_o | output | DW | Register file write data |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Unknown format pulse |

## Verification
The error pulse is due one cycle after the start edge and the done pulse one cycle after the last completion event: the final store acceptance, or the final load register write, which itself follows the last acceptance by one cycle. The bench timestamps every acceptance, register write and pulse with a running cycle counter at the clock edge and compares these stamps, so memory wait states of zero, one and two cycles do not move the expected offsets. All outputs are sampled on the falling edge, half a period after the edge that moved them, and the address stream and final memory or register contents are compared against a model built from the format table.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int FMT_COUNT  = 11;
    localparam int VIDX_W     = 5;

    typedef struct packed {
        logic [2:0] nregs;
        logic [2:0] ilv;
        logic [1:0] spc;
    } fmt_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_FETCH,
        S_ACCESS,
        S_WRITE,
        S_FINISH
    } st_t;

    function automatic fmt_t fmt_lookup(input logic [3:0] code);
        fmt_t f;
        unique case (code)
            4'd0:    f = '{3'd4, 3'd4, 2'd1};
            4'd1:    f = '{3'd4, 3'd4, 2'd2};
            4'd2:    f = '{3'd4, 3'd1, 2'd1};
            4'd3:    f = '{3'd4, 3'd2, 2'd1};
            4'd4:    f = '{3'd3, 3'd3, 2'd1};
            4'd5:    f = '{3'd3, 3'd3, 2'd2};
            4'd6:    f = '{3'd3, 3'd1, 2'd1};
            4'd7:    f = '{3'd1, 3'd1, 2'd1};
            4'd8:    f = '{3'd2, 3'd2, 2'd1};
            4'd9:    f = '{3'd2, 3'd2, 2'd2};
            4'd10:   f = '{3'd2, 3'd1, 2'd1};
            default: f = '{3'd1, 3'd1, 2'd1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/vls_decode.sv
module vls_decode
    import vls_pkg::*;
(
    input  logic [31:0]       instr_i,
    output fmt_t              info_o,
    output logic [1:0]        size_o,
    output logic              load_o,
    output logic [VIDX_W-1:0] first_o,
    output logic              legal_o
);
    logic [3:0] code;
    logic       unused_bits;

    assign code        = instr_i[11:8];
    assign size_o      = instr_i[7:6];
    assign load_o      = instr_i[21];
    assign first_o     = {instr_i[22], instr_i[15:12]};
    assign legal_o     = (code <= 4'(FMT_COUNT - 1));
    assign info_o      = fmt_lookup(code);
    assign unused_bits = ^{instr_i[31:23], instr_i[20:16], instr_i[5:0]};
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] cur_i,
    input  logic [1:0]    reg_i,
    input  logic [1:0]    size_i,
    input  fmt_t          info_i,
    output logic [AW-1:0] restart_o,
    output logic [AW-1:0] stride_o
);
    logic [AW-1:0] esz;
    logic          per_reg;
    logic          pair_mid;

    assign esz      = AW'(1) << size_i;
    assign stride_o = esz * AW'(info_i.ilv);
    assign per_reg  = (info_i.ilv > 3'd2) ||
                      ((info_i.ilv == 3'd2) && (info_i.nregs == 3'd2));
    assign pair_mid = (info_i.ilv == 3'd2) && (info_i.nregs == 3'd4) &&
                      (reg_i == 2'd2);

    always_comb begin
        if (per_reg) begin
            restart_o = base_i + esz * AW'(reg_i);
        end else if (pair_mid) begin
            restart_o = base_i + esz;
        end else begin
            restart_o = cur_i;
        end
    end
endmodule

// File: rtl/vls_lane.sv
module vls_lane #(
    parameter int DW = 64
) (
    input  logic [DW-1:0]                buf_i,
    input  logic [DW-1:0]                rdata_i,
    input  logic [$clog2(DW/8)-1:0]      elem_i,
    input  logic [1:0]                   size_i,
    output logic [DW-1:0]                merged_o,
    output logic [DW-1:0]                elem_o
);
    localparam int NB = DW / 8;
    localparam int BW = $clog2(NB);
    localparam int OW = BW + 1;

    logic [OW-1:0] off;
    logic [OW-1:0] nbytes;
    logic [DW-1:0] shifted;
    logic [DW-1:0] mask;

    assign off     = OW'(elem_i) << size_i;
    assign nbytes  = OW'(1) << size_i;
    assign shifted = buf_i >> {off[BW-1:0], 3'b000};

    always_comb begin
        mask = '0;
        for (int k = 0; k < NB; k++) begin
            if (OW'(k) < nbytes) begin
                mask[8*k +: 8] = 8'hFF;
            end
        end
    end

    assign elem_o = shifted & mask;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [OW-1:0] rel;
        logic          hit;
        assign rel = OW'(b) - off;
        assign hit = (OW'(b) >= off) && (rel < nbytes);
        assign merged_o[8*b +: 8] = hit ? rdata_i[8*rel[BW-1:0] +: 8]
                                        : buf_i[8*b +: 8];
    end
endmodule

// File: rtl/vstruct_seq.sv
module vstruct_seq
    import vls_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [AW-1:0]     base_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [1:0]        mem_size_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              vrf_re_o,
    output logic [4:0]        vrf_raddr_o,
    input  logic [DW-1:0]     vrf_rdata_i,
    output logic              vrf_we_o,
    output logic [4:0]        vrf_waddr_o,
    output logic [DW-1:0]     vrf_wdata_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int NB = DW / 8;
    localparam int EW = $clog2(NB);

    st_t               st_q, st_d;
    fmt_t              info_q;
    logic [1:0]        size_q;
    logic              load_q;
    logic [VIDX_W-1:0] vreg_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     addr_q;
    logic [1:0]        reg_q;
    logic [EW-1:0]     elem_q;
    logic [DW-1:0]     buf_q;
    logic              err_q;

    fmt_t              dec_info;
    logic [1:0]        dec_size;
    logic              dec_load;
    logic [VIDX_W-1:0] dec_first;
    logic              dec_legal;
    logic [AW-1:0]     restart_addr;
    logic [AW-1:0]     stride;
    logic [DW-1:0]     merged;
    logic [DW-1:0]     elem_out;
    logic [EW-1:0]     elem_last;
    logic              elem_is_last;
    logic              reg_is_last;
    logic              accept;
    logic              reg_done;

    vls_decode u_dec (
        .instr_i (instr_i),
        .info_o  (dec_info),
        .size_o  (dec_size),
        .load_o  (dec_load),
        .first_o (dec_first),
        .legal_o (dec_legal)
    );

    vls_addr_gen #(.AW(AW)) u_agen (
        .base_i    (base_q),
        .cur_i     (addr_q),
        .reg_i     (reg_q),
        .size_i    (size_q),
        .info_i    (info_q),
        .restart_o (restart_addr),
        .stride_o  (stride)
    );

    vls_lane #(.DW(DW)) u_lane (
        .buf_i    (buf_q),
        .rdata_i  (mem_rdata_i),
        .elem_i   (elem_q),
        .size_i   (size_q),
        .merged_o (merged),
        .elem_o   (elem_out)
    );

    assign elem_last    = EW'((NB >> size_q) - 1);
    assign elem_is_last = (elem_q == elem_last);
    assign reg_is_last  = (3'(reg_q) == info_q.nregs - 3'd1);
    assign accept       = (st_q == S_ACCESS) && mem_ready_i;
    assign reg_done     = (accept && elem_is_last && !load_q) || (st_q == S_WRITE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start_i && dec_legal) st_d = S_SETUP;
            S_SETUP:  st_d = load_q ? S_ACCESS : S_FETCH;
            S_FETCH:  st_d = S_ACCESS;
            S_ACCESS: begin
                if (mem_ready_i && elem_is_last) begin
                    if (load_q)           st_d = S_WRITE;
                    else if (reg_is_last) st_d = S_FINISH;
                    else                  st_d = S_SETUP;
                end
            end
            S_WRITE:  st_d = reg_is_last ? S_FINISH : S_SETUP;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q <= '{3'd1, 3'd1, 2'd1};
            size_q <= '0;
            load_q <= 1'b0;
            vreg_q <= '0;
            base_q <= '0;
            addr_q <= '0;
            reg_q  <= '0;
            elem_q <= '0;
            buf_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= (st_q == S_IDLE) && start_i && !dec_legal;
            if (st_q == S_IDLE && start_i && dec_legal) begin
                info_q <= dec_info;
                size_q <= dec_size;
                load_q <= dec_load;
                vreg_q <= dec_first;
                base_q <= base_i;
                addr_q <= base_i;
                reg_q  <= '0;
            end
            if (st_q == S_SETUP) begin
                addr_q <= restart_addr;
                elem_q <= '0;
                buf_q  <= '0;
            end
            if (st_q == S_FETCH) begin
                buf_q <= vrf_rdata_i;
            end
            if (accept) begin
                addr_q <= addr_q + stride;
                elem_q <= elem_q + EW'(1);
                if (load_q) buf_q <= merged;
            end
            if (reg_done) begin
                reg_q  <= reg_q + 2'd1;
                vreg_q <= vreg_q + VIDX_W'(info_q.spc);
            end
        end
    end

    always_comb begin
        mem_req_o   = (st_q == S_ACCESS);
        mem_we_o    = (st_q == S_ACCESS) && !load_q;
        mem_addr_o  = addr_q;
        mem_size_o  = size_q;
        mem_wdata_o = elem_out;
        vrf_re_o    = (st_q == S_SETUP) && !load_q;
        vrf_raddr_o = vreg_q;
        vrf_we_o    = (st_q == S_WRITE);
        vrf_waddr_o = vreg_q;
        vrf_wdata_o = buf_q;
        done_o      = (st_q == S_FINISH);
        err_o       = err_q;
    end
endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [1:0]    mem_size_o,
    input logic          mem_ready_i,
    input logic          vrf_re_o,
    input logic          vrf_we_o,
    input logic          done_o,
    input logic          err_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
        $stable(mem_we_o) && $stable(mem_size_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o && !done_o); // R11

    AST_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_we_o |-> !mem_req_o && !vrf_re_o); // R8

    AST_READ_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_re_o |=> !mem_req_o && !vrf_re_o); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R11
endmodule

bind vstruct_seq vls_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_size_o  (mem_size_o),
    .mem_ready_i (mem_ready_i),
    .vrf_re_o    (vrf_re_o),
    .vrf_we_o    (vrf_we_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/vstruct_seq_tb.sv
module vstruct_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [31:0]   instr_i = '0;
    logic [AW-1:0] base_i = '0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [1:0]    mem_size_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i;
    logic          mem_ready_i = 1'b0;
    logic          vrf_re_o, vrf_we_o;
    logic [4:0]    vrf_raddr_o, vrf_waddr_o;
    logic [DW-1:0] vrf_rdata_i = '0;
    logic [DW-1:0] vrf_wdata_o;
    logic          done_o, err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    vstruct_seq #(.AW(AW), .DW(DW)) u_dut (.*);

    logic [7:0]  mem     [0:255];
    logic [7:0]  exp_mem [0:255];
    logic [63:0] vrf     [0:31];
    logic [63:0] exp_vrf [0:31];
    logic [31:0] hs_addr [0:63];
    logic [31:0] exp_addr[0:63];
    int exp_n, hs_n, bad_size, we_n, re_n, err_seen, viol;
    int cyc, last_hs, last_we;
    int wait_n, wcnt;
    logic [1:0] cur_size;
    int n_chk = 0, n_fail = 0;
    logic        p_req, p_rdy, p_we;
    logic [31:0] p_addr;

    function automatic logic [63:0] mem_rd(input logic [31:0] a, input logic [1:0] sz);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++)
            if (k < (1 << sz)) r[8*k +: 8] = mem[8'(a + 32'(k))];
        return r;
    endfunction

    always_comb mem_rdata_i = mem_rd(mem_addr_o, mem_size_o);

    // Memory, register file and event logger
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req_o && mem_ready_i) begin
                if (hs_n < 64) hs_addr[hs_n] = mem_addr_o;
                hs_n++;
                last_hs = cyc;
                if (mem_size_o != cur_size) bad_size++;
                if (mem_we_o)
                    for (int k = 0; k < 8; k++)
                        if (k < (1 << mem_size_o)) mem[8'(mem_addr_o + 32'(k))] = mem_wdata_o[8*k +: 8];
            end
            if (vrf_re_o) begin vrf_rdata_i <= vrf[vrf_raddr_o]; re_n++; end
            if (vrf_we_o) begin vrf[vrf_waddr_o] = vrf_wdata_o; we_n++; last_we = cyc; end
            if (err_o) err_seen++;
        end
        cyc = cyc + 1;
    end

    // Ready generator and request-hold monitor (R7)
    always @(negedge clk) begin
        if (p_req && !p_rdy && (!mem_req_o || mem_addr_o != p_addr || mem_we_o != p_we)) viol++;
        p_req = mem_req_o; p_addr = mem_addr_o; p_we = mem_we_o;
        if (mem_req_o && !mem_ready_i) begin
            if (wcnt >= wait_n) mem_ready_i = 1'b1;
            else wcnt++;
        end else begin
            mem_ready_i = 1'b0;
            wcnt = 0;
        end
        p_rdy = mem_ready_i;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit ld, input int fmt, input int sz, input int rd);
        logic [31:0] i = '0;
        i[22] = rd[4]; i[21] = ld; i[19:16] = 4'h5;
        i[15:12] = rd[3:0]; i[11:8] = fmt[3:0]; i[7:6] = sz[1:0];
        return i;
    endfunction

    // R2 table as stated in the requirement
    task automatic shape(input int fmt, output int nr, output int il, output int sp);
        case (fmt)
            0: begin nr = 4; il = 4; sp = 1; end
            1: begin nr = 4; il = 4; sp = 2; end
            2: begin nr = 4; il = 1; sp = 1; end
            3: begin nr = 4; il = 2; sp = 1; end
            4: begin nr = 3; il = 3; sp = 1; end
            5: begin nr = 3; il = 3; sp = 2; end
            6: begin nr = 3; il = 1; sp = 1; end
            7: begin nr = 1; il = 1; sp = 1; end
            8: begin nr = 2; il = 2; sp = 1; end
            9: begin nr = 2; il = 2; sp = 2; end
            default: begin nr = 2; il = 1; sp = 1; end
        endcase
    endtask

    task automatic model(input bit ld, input int fmt, input int sz, input int rd0, input logic [31:0] base);
        int nr, il, sp, es, ne, rd;
        logic [31:0] a;
        shape(fmt, nr, il, sp);
        es = 1 << sz; ne = 8 >> sz; rd = rd0; a = base; exp_n = 0;
        for (int r = 0; r < nr; r++) begin
            logic [63:0] img;
            if (il > 2 || (il == 2 && nr == 2)) a = base + 32'(es * r);
            else if (il == 2 && nr == 4 && r == 2) a = base + 32'(es);
            img = ld ? 64'h0 : exp_vrf[rd];
            for (int e = 0; e < ne; e++) begin
                exp_addr[exp_n] = a; exp_n++;
                for (int k = 0; k < es; k++) begin
                    if (ld) img[8*(e*es+k) +: 8] = exp_mem[8'(a + 32'(k))];
                    else    exp_mem[8'(a + 32'(k))] = img[8*(e*es+k) +: 8];
                end
                a = a + 32'(es * il);
            end
            if (ld) exp_vrf[rd] = img;
            rd = (rd + sp) % 32;
        end
    endtask

    task automatic run_xfer(input string name, input bit ld, input int fmt, input int sz,
                            input int rd, input logic [31:0] base, input int w, input bit inject);
        int nr, il, sp, done_cyc, bad;
        bit seen;
        for (int k = 0; k < 256; k++) exp_mem[k] = mem[k];
        for (int k = 0; k < 32; k++) exp_vrf[k] = vrf[k];
        model(ld, fmt, sz, rd, base);
        shape(fmt, nr, il, sp);
        hs_n = 0; bad_size = 0; we_n = 0; re_n = 0; err_seen = 0; viol = 0;
        wait_n = w; cur_size = 2'(sz);
        @(negedge clk);
        start_i = 1'b1; instr_i = mk(ld, fmt, sz, rd); base_i = base;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0; done_cyc = 0;
        for (int t = 0; t < 3000; t++) begin
            if (done_o) begin seen = 1; done_cyc = cyc; break; end
            if (inject && t == 3) begin
                start_i = 1'b1; instr_i = mk(1, 13, 0, 0); base_i = 32'hF0;
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(seen, "R10", {name, " done seen"}, 64'(seen), 64'd1);
        @(negedge clk);
        chk(!done_o, "R10", {name, " done one cycle"}, 64'(done_o), 64'd0);
        chk(hs_n == exp_n, "R2", {name, " element count"}, 64'(hs_n), 64'(exp_n));
        bad = 0;
        for (int k = 0; k < exp_n && k < 64; k++)
            if (hs_addr[k] != exp_addr[k]) begin
                if (bad == 0) chk(0, "R4", {name, " address stream"}, 64'(hs_addr[k]), 64'(exp_addr[k]));
                bad++;
            end
        if (bad == 0) chk(1, "R4", "", 0, 0);
        chk(bad_size == 0, "R3", {name, " size code"}, 64'(bad_size), 64'd0);
        chk(viol == 0, "R7", {name, " request hold"}, 64'(viol), 64'd0);
        if (ld) begin
            bad = 0;
            for (int k = 0; k < 32; k++) if (vrf[k] != exp_vrf[k]) begin
                if (bad == 0) chk(0, "R5", {name, " register image"}, vrf[k], exp_vrf[k]);
                bad++;
            end
            if (bad == 0) chk(1, "R6", "", 0, 0);
            chk(we_n == nr, "R8", {name, " write count"}, 64'(we_n), 64'(nr));
            chk(last_we == last_hs + 1, "R8", {name, " write after last element"}, 64'(last_we - last_hs), 64'd1);
            chk(done_cyc == last_we + 1, "R10", {name, " done timing"}, 64'(done_cyc - last_we), 64'd1);
        end else begin
            bad = 0;
            for (int k = 0; k < 256; k++) if (mem[k] != exp_mem[k]) begin
                if (bad == 0) chk(0, "R5", {name, " memory bytes"}, 64'(mem[k]), 64'(exp_mem[k]));
                bad++;
            end
            if (bad == 0) chk(1, "R6", "", 0, 0);
            chk(re_n == nr, "R9", {name, " read count"}, 64'(re_n), 64'(nr));
            chk(we_n == 0, "R8", {name, " no write on store"}, 64'(we_n), 64'd0);
            chk(done_cyc == last_hs + 1, "R10", {name, " done timing"}, 64'(done_cyc - last_hs), 64'd1);
        end
        if (inject) chk(err_seen == 0, "R12", {name, " start while busy ignored"}, 64'(err_seen), 64'd0);
    endtask

    task automatic t_reset();
        chk(!mem_req_o && !vrf_re_o && !vrf_we_o, "R13", "reset access", 64'({mem_req_o, vrf_re_o, vrf_we_o}), 64'd0);
        chk(!done_o && !err_o, "R13", "reset pulses", 64'({done_o, err_o}), 64'd0);
    endtask

    task automatic t_illegal(input int fmt);
        hs_n = 0; err_seen = 0; re_n = 0;
        @(negedge clk);
        start_i = 1'b1; instr_i = mk(1, fmt, 0, 2); base_i = 32'h10;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o == 1'b1, "R11", "error pulse next cycle", 64'(err_o), 64'd1);
        @(negedge clk);
        chk(!err_o && !done_o, "R11", "error one cycle, no done", 64'({err_o, done_o}), 64'd0);
        repeat (4) @(negedge clk);
        chk(hs_n == 0 && re_n == 0, "R11", "no access for unknown format", 64'(hs_n), 64'd0);
        chk(err_seen == 1, "R11", "error count", 64'(err_seen), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc = 0; hs_n = 0; we_n = 0; re_n = 0; err_seen = 0; viol = 0;
        wait_n = 0; wcnt = 0; bad_size = 0; cur_size = 0; last_hs = 0; last_we = 0;
        p_req = 0; p_rdy = 0; p_we = 0; p_addr = 0;
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 37 + 11);
        for (int k = 0; k < 32; k++) vrf[k] = 64'h0F1E2D3C4B5A6978 ^ (64'(k) * 64'h0101010101010101);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R1 field positions, R5 byte lanes, single register
        run_xfer("load fmt7 bytes", 1, 7, 0, 3, 32'h10, 0, 0);
        // R2 four-way, R6 wrap from index 30 (bit 22 set)
        run_xfer("load fmt0 halves", 1, 0, 1, 30, 32'h20, 1, 0);
        // R4 restart of register 2 at base+esize
        run_xfer("load fmt3 words", 1, 3, 2, 8, 32'h40, 0, 0);
        // R4 continuing address
        run_xfer("load fmt6 halves", 1, 6, 1, 17, 32'h80, 2, 0);
        run_xfer("load fmt10 dwords", 1, 10, 3, 12, 32'h90, 0, 0);
        // R9 store path, R6 spacing two
        run_xfer("store fmt1 bytes", 0, 1, 0, 4, 32'h30, 0, 0);
        run_xfer("store fmt9 dwords", 0, 9, 3, 20, 32'hA0, 1, 0);
        run_xfer("store fmt4 words", 0, 4, 2, 0, 32'hC0, 0, 0);
        run_xfer("store fmt5 halves", 0, 5, 1, 27, 32'h60, 2, 0);
        // R12 start while busy
        run_xfer("load fmt2 busy start", 1, 2, 0, 9, 32'h50, 1, 1);
        // R11 unknown formats
        t_illegal(11);
        t_illegal(15);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule